// File: doc/BRIEF.md
# Backup Domain Register Transfer Engine

This block copies a fixed set of nineteen byte-wide configuration registers between a main-side register file and a battery-backed backup register file. A save copies the main-side values into the backup side. A recall copies the backup values into the main side. Software starts either operation with a single write to a control interface that runs on the bus clock. The copy itself runs on a slow transfer clock, one byte per transfer-clock cycle. The registers always move in ascending order, so every operation takes nineteen transfer cycles.

The block keeps neither register file. It reads both files as flat vectors. It drives a single shared data byte, a bit mask and one write enable per register for each side. The owner of each register file applies `new = (old & ~mask) | (byte & mask)` on the transfer-clock edge. Register 18 holds a mix of bit types. Only its bits 0 and 2 take part in a transfer, and its other bits keep their values.

A trigger crosses into the transfer-clock domain as a toggle. Completion returns as a second toggle through a two-flop synchronizer. While an operation runs, `busy` is high. A sticky `done` flag tells software that the recalled values are ready to read.

Top module: `bkup_xfer_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every bit of `main_we` and `bkup_we` is 0.
- R2: A control write with `ctl_save`=1 and `ctl_recall`=0 starts a save. During a save only `bkup_we` is used, and `xfer_byte` carries the main-side byte of the register being written. At the end, every backup register holds its main-side value, and the main-side registers are unchanged.
- R3: A control write with `ctl_recall`=1 and `ctl_save`=0 starts a recall. During a recall only `main_we` is used, and `xfer_byte` carries the backup byte of the register being written. At the end, every main-side register holds its backup value, and the backup registers are unchanged.
- R4: In each operation, the write-enable bits fire on 19 consecutive transfer-clock cycles, one bit per cycle, in ascending order. Register k uses enable bit k-1.
- R5: When register 18 is written (enable bit 17), `xfer_mask` is 8'h05. At all other times it is 8'hFF. Only bits 0 and 2 of register 18 change; its other six bits keep their values.
- R6: A control write made while `busy` is 1 is ignored. It does not start, extend or redirect the running operation, and no second operation follows.
- R7: A control write with both `ctl_save` and `ctl_recall` set is rejected. `busy` stays 0, no write enable fires, and `done` keeps its value.
- R8: `busy` rises on the bus clock edge that accepts a trigger, and at that edge `done` clears. When the nineteenth byte has completed, `busy` falls and `done` becomes 1 and stays 1 until the next trigger is accepted.
- R9: A control write with neither `ctl_save` nor `ctl_recall` set has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Bus-domain reset, active low |
| sclk | input | 1 | Slow transfer clock |
| srst_n | input | 1 | Transfer-domain reset, active low |
| ctl_wr | input | 1 | Control register write strobe (bus clock) |
| ctl_save | input | 1 | Write data: request save |
| ctl_recall | input | 1 | Write data: request recall |
| busy | output | 1 | Operation in progress (bus clock) |
| done | output | 1 | Sticky completion flag (bus clock) |
| main_regs | input | 152 | Main-side register file, register k in bits [8k-1:8k-8] |
| bkup_regs | input | 152 | Backup register file, same layout |
| xfer_byte | output | 8 | Data byte for the register being written |
| xfer_mask | output | 8 | Bits of that byte to be written |
| main_we | output | 19 | Main-side write enables, one per register |
| bkup_we | output | 19 | Backup write enables, one per register |

## Verification
`busy` rises one bus clock after the accepted write. The bench samples `busy` on the next falling bus edge. The first write enable follows about three transfer cycles later, once the synchronizer and the sequencer start have passed, and then the enables fire on nineteen back-to-back transfer cycles. The bench records every enable on the falling transfer-clock edge, where the byte and the mask are settled, and checks their order and count. Completion reaches `done` two to three bus cycles after the last byte. The bench does not predict that edge. It polls on falling bus edges with a bounded wait, then compares both register files byte by byte with values its own functions compute. For rejected and ignored writes, the bench waits longer than a full operation would take before it checks that nothing changed.

// File: rtl/bkx_pkg.sv
package bkx_pkg;
    parameter int unsigned NUM_REGS   = 19;
    parameter int unsigned BYTE_W     = 8;
    parameter int unsigned MIXED_IDX  = 17;
    parameter logic [7:0]  MIXED_MASK = 8'h05;

    typedef enum logic {
        DIR_SAVE   = 1'b0,
        DIR_RECALL = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/bkx_sync2.sv
module bkx_sync2 #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] meta_q, meta_d;
    logic [WIDTH-1:0] out_q, out_d;

    always_comb begin
        meta_d = d_in;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            out_q  <= '0;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign d_out = out_q;
endmodule

// File: rtl/bkx_trig_ctl.sv
module bkx_trig_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_save,
    input  logic ctl_recall,
    input  logic done_tgl_s,
    output logic req_tgl,
    output logic dir,
    output logic busy,
    output logic done
);
    typedef struct packed {
        logic req_tgl;
        logic dir;
        logic busy;
        logic done;
        logic done_seen;
    } ctl_state_t;

    ctl_state_t s_q, s_d;
    logic       accept;

    always_comb begin
        s_d    = s_q;
        accept = ctl_wr && !s_q.busy && (ctl_save ^ ctl_recall);
        if (s_q.busy && (done_tgl_s != s_q.done_seen)) begin
            s_d.busy      = 1'b0;
            s_d.done      = 1'b1;
            s_d.done_seen = done_tgl_s;
        end
        if (accept) begin
            s_d.req_tgl = ~s_q.req_tgl;
            s_d.dir     = ctl_recall;
            s_d.busy    = 1'b1;
            s_d.done    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_tgl = s_q.req_tgl;
    assign dir     = s_q.dir;
    assign busy    = s_q.busy;
    assign done    = s_q.done;

    // R7: a start always stems from a write naming exactly one direction
    p_single_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_wr && (ctl_save != ctl_recall)));

    // R6: writes while busy leave the latched direction and toggle alone
    p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr) |=> ($stable(dir) && $stable(req_tgl)));

    // R8: busy and done never stand together
    p_busy_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

// File: rtl/bkx_sequencer.sv
module bkx_sequencer #(
    parameter int unsigned NUM_REGS = 19,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             sclk,
    input  logic             srst_n,
    input  logic             req_tgl_s,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             done_tgl
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    typedef struct packed {
        logic             req_seen;
        logic             active;
        logic [IDX_W-1:0] idx;
        logic             done_tgl;
    } seq_state_t;

    seq_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (s_q.active) begin
            if (s_q.idx == LAST_IDX) begin
                s_d.active   = 1'b0;
                s_d.idx      = '0;
                s_d.done_tgl = ~s_q.done_tgl;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else if (req_tgl_s != s_q.req_seen) begin
            s_d.req_seen = req_tgl_s;
            s_d.active   = 1'b1;
            s_d.idx      = '0;
        end
    end

    always_ff @(posedge sclk or negedge srst_n) begin
        if (!srst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign active   = s_q.active;
    assign idx      = s_q.idx;
    assign done_tgl = s_q.done_tgl;

    // R4: the index never leaves the register range
    p_idx_bound_r4: assert property (@(posedge sclk) disable iff (!srst_n)
        idx <= LAST_IDX);

    // R4: consecutive active cycles step the index by one
    p_idx_step_r4: assert property (@(posedge sclk) disable iff (!srst_n)
        (active && $past(active)) |-> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/bkup_xfer_engine.sv
module bkup_xfer_engine #(
    parameter int unsigned NUM_REGS   = bkx_pkg::NUM_REGS,
    parameter int unsigned BYTE_W     = bkx_pkg::BYTE_W,
    parameter int unsigned MIXED_IDX  = bkx_pkg::MIXED_IDX,
    parameter logic [7:0]  MIXED_MASK = bkx_pkg::MIXED_MASK
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       srst_n,
    input  logic                       ctl_wr,
    input  logic                       ctl_save,
    input  logic                       ctl_recall,
    output logic                       busy,
    output logic                       done,
    input  logic [NUM_REGS*BYTE_W-1:0] main_regs,
    input  logic [NUM_REGS*BYTE_W-1:0] bkup_regs,
    output logic [BYTE_W-1:0]          xfer_byte,
    output logic [BYTE_W-1:0]          xfer_mask,
    output logic [NUM_REGS-1:0]        main_we,
    output logic [NUM_REGS-1:0]        bkup_we
);
    import bkx_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic             req_tgl, req_tgl_s;
    logic             done_tgl, done_tgl_s;
    logic             dir;
    logic             active;
    logic [IDX_W-1:0] idx;
    logic [NUM_REGS-1:0] hit;

    bkx_trig_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_save   (ctl_save),
        .ctl_recall (ctl_recall),
        .done_tgl_s (done_tgl_s),
        .req_tgl    (req_tgl),
        .dir        (dir),
        .busy       (busy),
        .done       (done)
    );

    bkx_sync2 #(.WIDTH(1)) u_req_sync (
        .clk   (sclk),
        .rst_n (srst_n),
        .d_in  (req_tgl),
        .d_out (req_tgl_s)
    );

    bkx_sync2 #(.WIDTH(1)) u_done_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (done_tgl),
        .d_out (done_tgl_s)
    );

    bkx_sequencer #(.NUM_REGS(NUM_REGS)) u_seq (
        .sclk      (sclk),
        .srst_n    (srst_n),
        .req_tgl_s (req_tgl_s),
        .active    (active),
        .idx       (idx),
        .done_tgl  (done_tgl)
    );

    // dir is held stable for the whole operation, so it is read here without a synchronizer
    always_comb begin
        xfer_byte = '0;
        if (active) begin
            if (dir == DIR_RECALL) xfer_byte = bkup_regs[idx*BYTE_W +: BYTE_W];
            else                   xfer_byte = main_regs[idx*BYTE_W +: BYTE_W];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_we
        assign hit[g]     = active && (idx == IDX_W'(g));
        assign main_we[g] = hit[g] && (dir == DIR_RECALL);
        assign bkup_we[g] = hit[g] && (dir == DIR_SAVE);
    end

    if (MIXED_IDX < NUM_REGS) begin : g_mixed
        assign xfer_mask = hit[MIXED_IDX] ? BYTE_W'(MIXED_MASK) : '1;
    end else begin : g_plain
        assign xfer_mask = '1;
    end

    // R4: at most one register is written per transfer cycle
    p_we_onehot_r4: assert property (@(posedge sclk) disable iff (!srst_n)
        $onehot0({main_we, bkup_we}));

    // R2: a save never drives main-side enables
    p_save_side_r2: assert property (@(posedge sclk) disable iff (!srst_n)
        (|bkup_we) |-> (dir == DIR_SAVE));

    // R3: a recall never drives backup enables
    p_recall_side_r3: assert property (@(posedge sclk) disable iff (!srst_n)
        (|main_we) |-> (dir == DIR_RECALL));

    // R5: the mixed register is only ever written through its mask
    p_mixed_mask_r5: assert property (@(posedge sclk) disable iff (!srst_n)
        (main_we[MIXED_IDX] || bkup_we[MIXED_IDX]) |-> (xfer_mask == BYTE_W'(MIXED_MASK)));
endmodule

// File: tb/bkup_xfer_engine_test.sv
module bkup_xfer_engine_test;
    import bkx_pkg::*;

    localparam int N = NUM_REGS;

    logic clk = 1'b0, sclk = 1'b0;
    logic rst_n = 1'b0, srst_n = 1'b0;
    logic ctl_wr = 1'b0, ctl_save = 1'b0, ctl_recall = 1'b0;
    logic busy, done;
    logic [N*8-1:0] main_regs, bkup_regs;
    logic [7:0] xfer_byte, xfer_mask;
    logic [N-1:0] main_we, bkup_we;

    logic [7:0] main_mem [N];
    logic [7:0] bkup_mem [N];
    logic [7:0] exp_main [N];
    logic [7:0] exp_bkup [N];

    int checks = 0, fails = 0;
    int wcount = 0, last_idx = -1, order_bad = 0, mask_bad = 0;

    always #10 clk = ~clk;
    always #80 sclk = ~sclk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            main_regs[i*8 +: 8] = main_mem[i];
            bkup_regs[i*8 +: 8] = bkup_mem[i];
        end
    end

    bkup_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .srst_n(srst_n),
        .ctl_wr(ctl_wr), .ctl_save(ctl_save), .ctl_recall(ctl_recall),
        .busy(busy), .done(done),
        .main_regs(main_regs), .bkup_regs(bkup_regs),
        .xfer_byte(xfer_byte), .xfer_mask(xfer_mask),
        .main_we(main_we), .bkup_we(bkup_we)
    );

    // register-file owners: apply masked writes, log order
    always @(negedge sclk) begin
        for (int i = 0; i < N; i++) begin
            if (bkup_we[i] || main_we[i]) begin
                if (i != last_idx + 1) order_bad++;
                if (xfer_mask != ((i == int'(MIXED_IDX)) ? MIXED_MASK : 8'hFF)) mask_bad++;
                last_idx = i;
                wcount++;
            end
            if (bkup_we[i]) bkup_mem[i] = (bkup_mem[i] & ~xfer_mask) | (xfer_byte & xfer_mask);
            if (main_we[i]) main_mem[i] = (main_mem[i] & ~xfer_mask) | (xfer_byte & xfer_mask);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] merged(input int i, input logic [7:0] dst, input logic [7:0] src);
        if (i == int'(MIXED_IDX)) return (dst & ~MIXED_MASK) | (src & MIXED_MASK);
        return src;
    endfunction

    task automatic do_write(input logic s, input logic r);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_save = s; ctl_recall = r;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_save = 1'b0; ctl_recall = 1'b0;
    endtask

    task automatic randomize_mems();
        for (int i = 0; i < N; i++) begin
            main_mem[i] = 8'($urandom);
            bkup_mem[i] = 8'($urandom);
        end
    endtask

    task automatic run_op(input bit rec, input bit interfere);
        bit ok;
        for (int i = 0; i < N; i++) begin
            exp_main[i] = rec ? merged(i, main_mem[i], bkup_mem[i]) : main_mem[i];
            exp_bkup[i] = rec ? bkup_mem[i] : merged(i, bkup_mem[i], main_mem[i]);
        end
        wcount = 0; last_idx = -1; order_bad = 0; mask_bad = 0;
        do_write(!rec, rec);
        chk(busy === 1'b1, "R8 busy after trigger", 32'(busy), 1);
        chk(done === 1'b0, "R8 done cleared on trigger", 32'(done), 0);
        if (interfere) begin
            repeat (30) @(negedge clk);
            do_write(rec, !rec); // R6: opposite request while busy
            do_write(!rec, rec);
        end
        ok = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (!busy && done) begin ok = 1'b1; break; end
        end
        chk(ok, "R8 completion flagged", 32'(done), 1);
        if (interfere) begin
            repeat (600) @(negedge clk);
            chk(busy === 1'b0, "R6 no second operation", 32'(busy), 0);
        end
        chk(wcount == N, "R4 byte count", 32'(wcount), 32'(N));
        chk(order_bad == 0, "R4 ascending order", 32'(order_bad), 0);
        chk(mask_bad == 0, "R5 mask value", 32'(mask_bad), 0);
        for (int i = 0; i < N; i++) begin
            chk(main_mem[i] === exp_main[i], rec ? "R3 main byte" : "R2 main unchanged",
                32'(main_mem[i]), 32'(exp_main[i]));
            chk(bkup_mem[i] === exp_bkup[i], rec ? "R3 backup unchanged" : "R2 backup byte",
                32'(bkup_mem[i]), 32'(exp_bkup[i]));
        end
    endtask

    task automatic reject_case(input logic s, input logic r, input string tag);
        logic [7:0] m0 [N];
        logic [7:0] b0 [N];
        logic done0;
        for (int i = 0; i < N; i++) begin m0[i] = main_mem[i]; b0[i] = bkup_mem[i]; end
        done0 = done;
        wcount = 0;
        do_write(s, r);
        chk(busy === 1'b0, {tag, " busy stays low"}, 32'(busy), 0);
        repeat (600) @(negedge clk);
        chk(busy === 1'b0, {tag, " no late start"}, 32'(busy), 0);
        chk(wcount == 0, {tag, " no writes"}, 32'(wcount), 0);
        chk(done === done0, {tag, " done kept"}, 32'(done), 32'(done0));
        for (int i = 0; i < N; i++) begin
            chk(main_mem[i] === m0[i] && bkup_mem[i] === b0[i], {tag, " files unchanged"},
                {16'(main_mem[i]), 16'(bkup_mem[i])}, {16'(m0[i]), 16'(b0[i])});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        randomize_mems();
        repeat (3) @(negedge sclk);
        rst_n = 1'b1; srst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
        chk(done === 1'b0, "R1 done", 32'(done), 0);
        chk(main_we === '0 && bkup_we === '0, "R1 write enables", 32'({main_we, bkup_we}), 0);

        // directed: save, then recall with all-ones vs zeros in mixed register
        main_mem[MIXED_IDX] = 8'hFF; bkup_mem[MIXED_IDX] = 8'h00;
        run_op(1'b0, 1'b0);
        chk(bkup_mem[MIXED_IDX] === 8'h05, "R5 save mixed bits", 32'(bkup_mem[MIXED_IDX]), 8'h05);
        main_mem[MIXED_IDX] = 8'h00; bkup_mem[MIXED_IDX] = 8'hFA;
        run_op(1'b1, 1'b0);
        chk(main_mem[MIXED_IDX] === 8'h00, "R5 recall mixed bits", 32'(main_mem[MIXED_IDX]), 8'h00);

        // random mix
        for (int t = 0; t < 6; t++) begin
            randomize_mems();
            run_op(1'($urandom), 1'b0);
        end

        // R6: triggers while busy ignored
        randomize_mems();
        run_op(1'b0, 1'b1);
        randomize_mems();
        run_op(1'b1, 1'b1);

        // R7: both bits set rejected; R9: neither bit set
        randomize_mems();
        reject_case(1'b1, 1'b1, "R7");
        reject_case(1'b0, 1'b0, "R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule